// File: doc/BRIEF.md
# I2C Target Front End with General-Call Reset

This block is the serial front end of a register-based peripheral that sits on a two-wire I2C bus as a target. It oversamples SCL and SDA with the system clock, passes both through synchronisers and a glitch filter, and from the cleaned lines recognises start, repeated start and stop conditions. Bytes are shifted MSB first. The ninth clock of each byte carries the acknowledge, which the block drives as an open-drain low through an output enable. Only 7-bit addressing is used. The block's address is a fixed six-bit prefix, set by a parameter, followed by one bit taken from an address-select pin.

When the controller writes, each data byte is acknowledged and handed to a register file through a byte-wide write strobe. When the controller reads, the block takes the byte on its read-data port, sends it MSB first, and pulses a consume strobe so the register file can present the next byte. A not-acknowledge from the controller ends the read.

The block also decodes the general-call software reset: a start, then the byte 0x00, then the byte 0x06. It acknowledges both bytes. It pulses a reset output for one clock when it sees the filtered rising SCL edge of the acknowledge clock that follows 0x06.

Top module: `i2c_gcr_target`

## Requirements
- R1: After reset, sda_oe, gc_reset_o, wr_valid_o and rd_ack_o are all low.
- R2: A first byte whose upper seven bits equal {ADDR_PREFIX, addr_sel_i} is acknowledged (sda_oe high during the ninth clock). Bit 0 of that byte selects the role: 0 makes the block a receiver and 1 makes it a transmitter.
- R3: A first byte with any other address (apart from the general call) is not acknowledged, and the block ignores every later byte until the next start.
- R4: A first byte whose upper five bits are 11110 is never acknowledged, even when the configured address has that form.
- R5: In receive mode, each data byte is acknowledged. It appears on wr_data_o, MSB first as received, with exactly one wr_valid_o pulse per byte.
- R6: In transmit mode, the block sends rd_data_i MSB first (a 0 bit drives sda_oe high). It pulses rd_ack_o once for each byte it loads.
- R7: A not-acknowledge from the controller after a transmitted byte makes the block release SDA. It loads no further byte until a new start.
- R8: A repeated start restarts address matching, whatever the state of the current transfer.
- R9: The general-call byte 0x00 (R/W 0) is acknowledged, and a following 0x06 is acknowledged. gc_reset_o then pulses high for exactly one clock, after the ACK clock of the 0x06 byte rises and before it falls.
- R10: After a general-call byte, a second byte other than 0x06 is not acknowledged and produces no gc_reset_o pulse.
- R11: A pulse on SCL or SDA shorter than FILT_LEN clocks has no effect on the received data.
- R12: A stop returns the block to idle. Bytes clocked after a stop and without a new start are not acknowledged and produce no write.
- R13: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_sel_i | input | 1 | Address-select pin, lowest address bit |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| wr_valid_o | output | 1 | One-clock strobe: received data byte valid |
| wr_data_o | output | 8 | Received data byte |
| rd_data_i | input | 8 | Byte to transmit on the next read byte |
| rd_ack_o | output | 1 | One-clock strobe: rd_data_i has been taken |
| gc_reset_o | output | 1 | One-clock general-call reset pulse |

## Verification
The assertions check on every cycle that the reset pulse lasts exactly one clock and occurs only while the block holds an acknowledge, that a write strobe coincides with the block acknowledging, that write and read strobes never coincide, and that the SDA enable never changes while the filtered SCL is high. Address matching, the 10-bit exclusion, byte order in both directions, the end of a read on NACK, repeated-start handling, glitch rejection and the placement of the reset pulse inside the ACK clock only show up across whole bus transactions. The bench's bus-functional controller drives those transactions.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared constants and types for the I2C target front end.
// Assumes an 8-bit byte and 7-bit addressing only.
package i2c_tgt_pkg;

    localparam int BYTE_BITS = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_BITS + 1);

    localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
    localparam logic [7:0] GC_RESET_CMD = 8'h06;
    localparam logic [4:0] TEN_BIT_MARK = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_WAIT
    } tgt_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/i2c_glitch_filter.sv
// Module: i2c_glitch_filter
// Takes an already synchronised line and follows it only after it has
// held a new level for FILT_LEN consecutive clocks. Shorter pulses are
// dropped. Resets to the idle (high) level of an I2C line.
module i2c_glitch_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

    logic [CNT_W-1:0] run_cnt;

    // Count clocks of disagreement; adopt the new level once it persists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= 1'b1;
            run_cnt <= '0;
        end else if (din == dout) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_LAST) begin
            dout    <= din;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bus_monitor.sv
// Module: i2c_bus_monitor
// Brings SCL and SDA into the clock domain through two-flop
// synchronisers and glitch filters. From the cleaned levels it derives
// SCL edges and start/stop conditions. Both lines see identical latency,
// so their relative order is kept.
module i2c_bus_monitor
    import i2c_tgt_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output logic     scl_flt,
    output bus_evt_t evt
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] sync_a;
    logic [NLINES-1:0] sync_b;
    logic [NLINES-1:0] flt;
    logic [NLINES-1:0] flt_d;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        // Two-stage synchroniser for one line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_a[g] <= 1'b1;
                sync_b[g] <= 1'b1;
            end else begin
                sync_a[g] <= raw[g];
                sync_b[g] <= sync_a[g];
            end
        end

        i2c_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (sync_b[g]),
            .dout (flt[g])
        );
    end

    // Previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) flt_d <= '1;
        else        flt_d <= flt;
    end

    // Decode edges and bus conditions from current and previous levels.
    always_comb begin
        evt.scl_rise = flt[0] & ~flt_d[0];
        evt.scl_fall = ~flt[0] & flt_d[0];
        evt.start    = flt[0] & flt_d[0] & flt_d[1] & ~flt[1];
        evt.stop     = flt[0] & flt_d[0] & ~flt_d[1] & flt[1];
        evt.sda      = flt[1];
    end

    assign scl_flt = flt[0];
endmodule

// File: rtl/i2c_target_engine.sv
// Module: i2c_target_engine
// Byte-level protocol engine of the target. It works on the cleaned bus
// events: address match, receive and transmit shifting, acknowledge
// handling and general-call reset decode. SDA is only ever pulled low,
// and sda_oe is updated only on a filtered SCL falling edge, or cleared
// at a start/stop. Assumes the controller never stretches or holds SCL.
module i2c_target_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [5:0] ADDR_PREFIX = 6'b100100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  bus_evt_t   evt,
    input  logic       addr_sel_i,
    input  logic [7:0] rd_data_i,
    output logic       sda_oe,
    output logic       wr_valid_o,
    output logic [7:0] wr_data_o,
    output logic       rd_ack_o,
    output logic       gc_reset_o
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_BITS);

    tgt_state_e             state;
    logic [7:0]             shreg;
    logic [7:0]             txreg;
    logic [BIT_CNT_W-1:0]   bit_cnt;
    logic                   rw_read;
    logic                   gc_mode;
    logic                   gc_hit;
    logic                   ctrl_acked;
    logic                   own_match;
    logic                   gc_match;
    logic                   byte_done;

    // Address compare: own 7-bit address, never a 10-bit prefix form.
    always_comb begin
        own_match = (shreg[7:1] == {ADDR_PREFIX, addr_sel_i})
                    && (shreg[7:3] != TEN_BIT_MARK);
        gc_match  = (shreg == GC_ADDR_BYTE);
        byte_done = evt.scl_fall && (bit_cnt == LAST_BIT);
    end

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            txreg      <= '0;
            bit_cnt    <= '0;
            rw_read    <= 1'b0;
            gc_mode    <= 1'b0;
            gc_hit     <= 1'b0;
            ctrl_acked <= 1'b0;
            sda_oe     <= 1'b0;
            wr_valid_o <= 1'b0;
            wr_data_o  <= '0;
            rd_ack_o   <= 1'b0;
            gc_reset_o <= 1'b0;
        end else begin
            wr_valid_o <= 1'b0;
            rd_ack_o   <= 1'b0;
            gc_reset_o <= 1'b0;
            if (evt.stop) begin
                state   <= ST_IDLE;
                sda_oe  <= 1'b0;
                gc_mode <= 1'b0;
                gc_hit  <= 1'b0;
            end else if (evt.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                gc_mode <= 1'b0;
                gc_hit  <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (evt.scl_rise) begin
                            shreg   <= {shreg[6:0], evt.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            if (own_match) begin
                                rw_read <= shreg[0];
                                sda_oe  <= 1'b1;
                                state   <= ST_ADDR_ACK;
                            end else if (gc_match) begin
                                rw_read <= 1'b0;
                                gc_mode <= 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_ADDR_ACK;
                            end else begin
                                state   <= ST_WAIT;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_read) begin
                                txreg    <= rd_data_i;
                                rd_ack_o <= 1'b1;
                                sda_oe   <= ~rd_data_i[7];
                                state    <= ST_TX;
                            end else begin
                                sda_oe   <= 1'b0;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_RX: begin
                        if (evt.scl_rise) begin
                            shreg   <= {shreg[6:0], evt.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            if (gc_mode) begin
                                if (shreg == GC_RESET_CMD) begin
                                    gc_hit <= 1'b1;
                                    sda_oe <= 1'b1;
                                    state  <= ST_RX_ACK;
                                end else begin
                                    state  <= ST_WAIT;
                                end
                            end else begin
                                wr_valid_o <= 1'b1;
                                wr_data_o  <= shreg;
                                sda_oe     <= 1'b1;
                                state      <= ST_RX_ACK;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (evt.scl_rise && gc_hit) begin
                            gc_reset_o <= 1'b1;
                        end else if (evt.scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= gc_mode ? ST_WAIT : ST_RX;
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                        end else if (evt.scl_fall) begin
                            txreg  <= {txreg[6:0], 1'b0};
                            sda_oe <= ~txreg[6];
                        end
                    end
                    ST_TX_ACK: begin
                        if (evt.scl_rise) begin
                            ctrl_acked <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            bit_cnt <= '0;
                            if (ctrl_acked) begin
                                txreg    <= rd_data_i;
                                rd_ack_o <= 1'b1;
                                sda_oe   <= ~rd_data_i[7];
                                state    <= ST_TX;
                            end else begin
                                state    <= ST_WAIT;
                            end
                        end
                    end
                    default: begin
                        // ST_IDLE and ST_WAIT: only a start or stop moves on.
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_gcr_target.sv
// Module: i2c_gcr_target (top)
// I2C target front end: line conditioning and event decode feed the
// protocol engine. The target address is {ADDR_PREFIX, addr_sel_i};
// addr_sel_i is treated as a static strap. FILT_LEN sets the shortest
// line pulse, in clocks, that is accepted.
module i2c_gcr_target #(
    parameter logic [5:0] ADDR_PREFIX = 6'b100100,
    parameter int         FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       addr_sel_i,
    output logic       sda_oe,
    output logic       wr_valid_o,
    output logic [7:0] wr_data_o,
    input  logic [7:0] rd_data_i,
    output logic       rd_ack_o,
    output logic       gc_reset_o
);
    i2c_tgt_pkg::bus_evt_t evt;
    logic                  scl_flt;

    i2c_bus_monitor #(.FILT_LEN(FILT_LEN)) u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .scl_flt(scl_flt),
        .evt    (evt)
    );

    i2c_target_engine #(.ADDR_PREFIX(ADDR_PREFIX)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .addr_sel_i(addr_sel_i),
        .rd_data_i (rd_data_i),
        .sda_oe    (sda_oe),
        .wr_valid_o(wr_valid_o),
        .wr_data_o (wr_data_o),
        .rd_ack_o  (rd_ack_o),
        .gc_reset_o(gc_reset_o)
    );
endmodule

// File: rtl/i2c_gcr_target_chk.sv
// Module: i2c_gcr_target_chk
// Protocol checker bound into every i2c_gcr_target instance.
module i2c_gcr_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_flt,
    input logic sda_oe,
    input logic wr_valid_o,
    input logic rd_ack_o,
    input logic gc_reset_o
);
    // R9
    gc_pulse_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gc_reset_o |=> !gc_reset_o);

    // R9
    gc_pulse_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gc_reset_o |-> sda_oe);

    // R5
    wr_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> sda_oe);

    // R6
    strobes_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid_o && rd_ack_o));

    // R6
    rd_ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack_o |-> !scl_flt);

    // R13
    sda_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_flt);
endmodule

bind i2c_gcr_target i2c_gcr_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_flt   (scl_flt),
    .sda_oe    (sda_oe),
    .wr_valid_o(wr_valid_o),
    .rd_ack_o  (rd_ack_o),
    .gc_reset_o(gc_reset_o)
);

// File: tb/i2c_gcr_target_test.sv
// Bench: directed scenarios driven by a bus-functional I2C controller.
module i2c_gcr_target_test;
    localparam int Q = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic       addr_sel = 1'b0;
    logic [7:0] rd_base = 8'h00;
    logic [7:0] rd_idx = 8'h00;
    logic [7:0] rd_data;
    logic       sda_oe, oe_ten;
    logic       wr_valid, rd_ack, gc_reset;
    logic [7:0] wr_data;
    logic       wr_v2, rd_a2, gc_r2;
    logic [7:0] wr_d2;
    wire        sda_line = sda_drv & ~sda_oe & ~oe_ten;

    int checks = 0, failures = 0;
    int cyc = 0, gc_pulses = 0, gc_cyc = 0, ack_rise_cyc = 0;
    int wr_cnt = 0, oe_viol = 0;
    logic [7:0] wr_log [0:15];
    logic prev_oe = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    assign rd_data = rd_base + rd_idx;

    i2c_gcr_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .addr_sel_i(addr_sel), .sda_oe(sda_oe), .wr_valid_o(wr_valid),
        .wr_data_o(wr_data), .rd_data_i(rd_data), .rd_ack_o(rd_ack),
        .gc_reset_o(gc_reset)
    );

    // Second target whose configured address has the 10-bit form 11110xx.
    i2c_gcr_target #(.ADDR_PREFIX(6'b111100)) u_ten (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .addr_sel_i(1'b0), .sda_oe(oe_ten), .wr_valid_o(wr_v2),
        .wr_data_o(wr_d2), .rd_data_i(8'hFF), .rd_ack_o(rd_a2),
        .gc_reset_o(gc_r2)
    );

    // Register-file model and event recorders.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        prev_oe <= sda_oe;
        if (rst_n && sda_oe != prev_oe && scl_drv) oe_viol <= oe_viol + 1;
        if (rd_ack) rd_idx <= rd_idx + 8'd1;
        if (wr_valid) begin
            wr_log[wr_cnt[3:0]] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (gc_reset) begin
            gc_pulses <= gc_pulses + 1;
            gc_cyc <= cyc;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wq(Q);
        scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b0; wq(Q);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq(Q);
        scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b1; wq(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i];
            if (glitch && i == 4) begin
                wq(10); scl_drv = 1'b1; wq(1); scl_drv = 1'b0; wq(Q - 11);
            end else wq(Q);
            scl_drv = 1'b1; wq(2 * Q);
            scl_drv = 1'b0; wq(Q);
        end
        sda_drv = 1'b1; wq(Q);
        scl_drv = 1'b1; ack_rise_cyc = cyc; wq(Q);
        acked = ~sda_line; wq(Q);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] d);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); scl_drv = 1'b1; wq(Q);
            d[i] = sda_line; wq(Q);
            scl_drv = 1'b0; wq(Q);
        end
        sda_drv = ~ack; wq(Q);
        scl_drv = 1'b1; wq(2 * Q);
        scl_drv = 1'b0; wq(Q);
        sda_drv = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 sda_oe", sda_oe, 0);
        check("R1 gc_reset", gc_reset, 0);
        check("R1 wr_valid", wr_valid, 0);
        check("R1 rd_ack", rd_ack, 0);
    endtask

    task automatic t_write();
        bit a; int n0 = wr_cnt;
        addr_sel = 1'b0;
        bus_start();
        send_byte(8'h90, 0, a); check("R2 own address write ack", a, 1);
        send_byte(8'h3C, 0, a); check("R5 data ack 1", a, 1);
        send_byte(8'hC3, 0, a); check("R5 data ack 2", a, 1);
        bus_stop();
        check("R5 write count", wr_cnt - n0, 2);
        check("R5 first byte", wr_log[n0[3:0]], 8'h3C);
        check("R5 second byte", wr_log[n0[3:0] + 4'd1], 8'hC3);
    endtask

    task automatic t_addr_sel();
        bit a;
        addr_sel = 1'b1;
        bus_start(); send_byte(8'h92, 0, a); bus_stop();
        check("R2 address with select pin high", a, 1);
        bus_start(); send_byte(8'h90, 0, a); bus_stop();
        check("R3 select bit mismatch nack", a, 0);
        addr_sel = 1'b0;
    endtask

    task automatic t_mismatch();
        bit a; int n0 = wr_cnt;
        bus_start();
        send_byte(8'h20, 0, a); check("R3 foreign address nack", a, 0);
        send_byte(8'h55, 0, a); check("R3 later byte nack", a, 0);
        bus_stop();
        check("R3 no write", wr_cnt - n0, 0);
    endtask

    task automatic t_ten_bit();
        bit a;
        bus_start(); send_byte(8'hF0, 0, a); bus_stop();
        check("R4 10-bit prefix nack", a, 0);
    endtask

    task automatic t_read();
        bit a; logic [7:0] d; logic [7:0] i0;
        rd_base = 8'h5A;
        wq(2);
        i0 = rd_idx;
        bus_start();
        send_byte(8'h91, 0, a); check("R2 own address read ack", a, 1);
        recv_byte(1, d); check("R6 read byte 0", d, 8'h5A + i0);
        recv_byte(1, d); check("R6 read byte 1", d, 8'h5A + i0 + 8'd1);
        recv_byte(0, d); check("R6 read byte 2", d, 8'h5A + i0 + 8'd2);
        check("R6 consume count", rd_idx - i0, 3);
        recv_byte(0, d); check("R7 SDA released after nack", d, 8'hFF);
        check("R7 no load after nack", rd_idx - i0, 3);
        check("R7 sda_oe low", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_rep_start();
        bit a; logic [7:0] d; logic [7:0] i0; int n0 = wr_cnt;
        rd_base = 8'h81;
        wq(2);
        i0 = rd_idx;
        bus_start();
        send_byte(8'h90, 0, a);
        send_byte(8'hA7, 0, a);
        bus_start();
        send_byte(8'h91, 0, a); check("R8 repeated start re-address", a, 1);
        recv_byte(0, d); check("R8 read after repeated start", d, 8'h81 + i0);
        bus_start();
        send_byte(8'h20, 0, a); check("R8 repeated start to foreign address", a, 0);
        bus_stop();
        check("R8 write before repeated start", wr_log[n0[3:0]], 8'hA7);
    endtask

    task automatic t_gc_reset();
        bit a; int p0 = gc_pulses;
        bus_start();
        send_byte(8'h00, 0, a); check("R9 general call ack", a, 1);
        check("R9 no pulse after first byte", gc_pulses - p0, 0);
        send_byte(8'h06, 0, a); check("R9 reset command ack", a, 1);
        check("R9 one pulse", gc_pulses - p0, 1);
        check("R9 pulse after ack rise", int'(gc_cyc > ack_rise_cyc), 1);
        check("R9 pulse before ack fall", int'(gc_cyc < ack_rise_cyc + 2 * Q), 1);
        bus_stop();
        check("R9 no extra pulse", gc_pulses - p0, 1);
    endtask

    task automatic t_gc_bad();
        bit a; int p0 = gc_pulses;
        bus_start();
        send_byte(8'h00, 0, a);
        send_byte(8'h05, 0, a); check("R10 wrong command nack", a, 0);
        bus_stop();
        check("R10 no pulse", gc_pulses - p0, 0);
    endtask

    task automatic t_glitch();
        bit a; int n0 = wr_cnt;
        bus_start();
        send_byte(8'h90, 0, a);
        send_byte(8'h81, 1, a); check("R11 glitched byte ack", a, 1);
        bus_stop();
        check("R11 byte intact", wr_log[n0[3:0]], 8'h81);
    endtask

    task automatic t_no_start();
        bit a; int n0 = wr_cnt;
        send_byte(8'h90, 0, a); check("R12 no start nack", a, 0);
        send_byte(8'h11, 0, a);
        bus_stop();
        check("R12 no write without start", wr_cnt - n0, 0);
    endtask

    initial begin
        wq(5);
        t_reset();
        rst_n = 1'b1;
        wq(5);
        t_write();
        t_addr_sel();
        t_mismatch();
        t_ten_bit();
        t_read();
        t_rep_start();
        t_gc_reset();
        t_gc_bad();
        t_glitch();
        t_no_start();
        check("R13 sda_oe changed while SCL high", oe_viol, 0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule